// File: doc/BRIEF.md
# Smart-Card Convention Serial Codec

This block moves characters over a single half-duplex line of the kind a smart card uses. Its transmit half turns a byte into a character on the line: a low start bit, eight data bits and a parity bit, then two high guard periods. Every bit lasts a number of clock cycles set by a run-time input. Its receive half watches the line and times each bit from the falling edge of the start bit. It rebuilds the byte, checks its parity and hands the result over with a one-cycle valid pulse.

One mode input selects the character convention for both halves together. The direct convention sends data as-is, least-significant bit first, with even parity. The inverse convention inverts every data bit, sends the most-significant bit first, and uses odd parity on the line. Each half samples the mode once per character, when that character starts. A host can therefore change the mode at any time without breaking a character that is already in flight.

Top module: `sc_codec`

## Requirements
- R1: After reset, `line_out` is high and `tx_busy`, `rx_valid` and `rx_overrun` are low. `line_out` stays high whenever the transmitter is idle.
- R2: With `conv_inverse` = 0 (direct), the transmitted data bits appear on the line unchanged in the order D0, D1, ... D7. The parity bit that follows makes the number of high bits among the nine even.
- R3: With `conv_inverse` = 1 (inverse), each data bit is inverted and the bits go out in the order D7, D6, ... D0. The parity bit makes the number of high bits among the nine line bits odd.
- R4: A transmitted character occupies 12 bit periods of `bit_cycles` clocks each, in this order: one low start bit, eight data bits, one parity bit, two high guard bits. `line_out` shows the start bit from the clock after the strobe is accepted. `tx_busy` rises with the start bit and falls exactly 12×`bit_cycles` clocks later.
- R5: A `tx_start` pulse while `tx_busy` is high is ignored. The character in progress and its data are unchanged.
- R6: In direct mode the receiver stores the first data bit it samples into `rx_data[0]` and the eighth into `rx_data[7]`, without inversion.
- R7: In inverse mode the receiver inverts each sampled data bit and stores the first into `rx_data[7]` and the eighth into `rx_data[0]`.
- R8: `rx_parity_err` is set with a received byte exactly when the nine sampled line bits break the rule of the mode: an even count of high bits in direct mode, an odd count in inverse mode.
- R9: Each received character produces exactly one `rx_valid` pulse, one clock long. `rx_data` and `rx_parity_err` are valid with it and hold until the next character.
- R10: `rx_overrun` is set with a new byte when the previous byte was not acknowledged by `rx_read`. A `rx_read` pulse with no new byte clears it.
- R11: Each half samples the mode when its character starts. Changing `conv_inverse` in the middle of a character does not affect that character on either path.
- R12: The receiver samples each bit at the middle of its period, counted from the detected falling edge. A low pulse that ends before the middle of the start bit is rejected, and no byte is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_inverse | input | 1 | 0 = direct convention, 1 = inverse convention |
| bit_cycles | input | CNT_W | Clock cycles per bit period (at least 4) |
| tx_start | input | 1 | Start strobe for a new character |
| tx_data | input | 8 | Byte to transmit, taken with the strobe |
| tx_busy | output | 1 | High from the start bit through the end of the guard time |
| line_out | output | 1 | Transmit line level, idles high |
| line_in | input | 1 | Receive line level |
| rx_read | input | 1 | Host acknowledge of the held byte |
| rx_data | output | 8 | Last received byte |
| rx_parity_err | output | 1 | Parity failure of the last received byte |
| rx_valid | output | 1 | One-clock pulse when a byte is written |
| rx_overrun | output | 1 | Previous byte was overwritten before it was read |

## Verification
The bench targets the boundaries between bit periods. It samples each transmitted bit at mid-period and checks that `tx_busy` falls on exactly the right clock, so a design with an off-by-one in its period counter would shift bits or cut a guard bit short. It flips the mode shortly after a character starts and sends a strobe while busy, which exposes any design that re-reads the mode or reloads its shifter mid-character. On the receive side it injects bad parity in both conventions, sends a short low glitch, and sends back-to-back bytes without an acknowledge. Swapped parity sense, a receiver that triggers on noise, or a missing overrun would each show up as a wrong flag or a wrong byte count.

// File: rtl/sc_codec_pkg.sv
package sc_codec_pkg;

    typedef enum logic {
        CONV_DIRECT  = 1'b0,
        CONV_INVERSE = 1'b1
    } conv_e;

    localparam int DATA_W     = 8;
    localparam int CHAR_BITS  = DATA_W + 1;          // data plus parity
    localparam int GUARD_BITS = 2;
    localparam int FRAME_LEN  = 1 + CHAR_BITS + GUARD_BITS;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              perr;
    } rx_result_t;

    // Line bits of one character in send order: [0] first, [DATA_W] parity.
    function automatic logic [CHAR_BITS-1:0] enc_char(input logic [DATA_W-1:0] d,
                                                      input conv_e c);
        logic [CHAR_BITS-1:0] b;
        for (int i = 0; i < DATA_W; i++) begin
            b[i] = (c == CONV_INVERSE) ? ~d[DATA_W-1-i] : d[i];
        end
        b[DATA_W] = (c == CONV_INVERSE) ? ~(^b[DATA_W-1:0]) : (^b[DATA_W-1:0]);
        return b;
    endfunction

    function automatic rx_result_t dec_char(input logic [CHAR_BITS-1:0] b,
                                            input conv_e c);
        rx_result_t r;
        for (int i = 0; i < DATA_W; i++) begin
            if (c == CONV_INVERSE) r.data[DATA_W-1-i] = ~b[i];
            else                   r.data[i]          =  b[i];
        end
        r.perr = (c == CONV_INVERSE) ? ~(^b) : (^b);
        return r;
    endfunction

endpackage

// File: rtl/sc_tx.sv
module sc_tx
    import sc_codec_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  conv_e                 mode_i,
    input  logic [CNT_W-1:0]      bit_cycles,
    input  logic                  start_i,
    input  logic [DATA_W-1:0]     data_i,
    output logic                  busy_o,
    output logic                  line_o
);
    localparam int IDX_W = $clog2(FRAME_LEN);

    logic [FRAME_LEN-1:0] sh_q;
    logic [CNT_W-1:0]     cyc_q;
    logic [IDX_W-1:0]     idx_q;
    logic                 busy_q;
    logic                 period_end;

    assign period_end = (cyc_q == bit_cycles - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '1;
            cyc_q  <= '0;
            idx_q  <= '0;
            busy_q <= 1'b0;
        end else if (!busy_q) begin
            if (start_i) begin
                sh_q   <= {{GUARD_BITS{1'b1}}, enc_char(data_i, mode_i), 1'b0};
                busy_q <= 1'b1;
                cyc_q  <= '0;
                idx_q  <= '0;
            end
        end else if (period_end) begin
            cyc_q <= '0;
            if (idx_q == IDX_W'(FRAME_LEN - 1)) begin
                busy_q <= 1'b0;
            end else begin
                idx_q <= idx_q + 1'b1;
                sh_q  <= {1'b1, sh_q[FRAME_LEN-1:1]};
            end
        end else begin
            cyc_q <= cyc_q + 1'b1;
        end
    end

    assign busy_o = busy_q;
    assign line_o = busy_q ? sh_q[0] : 1'b1;

    p_start_low_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_q) |-> !line_o);

    p_guard_high_r4: assert property (@(posedge clk) disable iff (rst)
        (busy_q && idx_q >= IDX_W'(FRAME_LEN - GUARD_BITS)) |-> line_o);

    p_strobe_ignored_r5: assert property (@(posedge clk) disable iff (rst)
        (busy_q && start_i && !period_end) |=> $stable(sh_q));

endmodule

// File: rtl/sc_rx.sv
module sc_rx
    import sc_codec_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  conv_e                 mode_i,
    input  logic [CNT_W-1:0]      bit_cycles,
    input  logic                  line_i,
    input  logic                  read_i,
    output logic [DATA_W-1:0]     data_o,
    output logic                  perr_o,
    output logic                  valid_o,
    output logic                  overrun_o
);
    localparam int IDX_W = $clog2(CHAR_BITS);

    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_state_e;

    rx_state_e            st_q;
    logic [2:0]           sync_q;
    logic [CNT_W-1:0]     cnt_q;
    logic [IDX_W-1:0]     idx_q;
    logic [CHAR_BITS-1:0] sh_q;
    conv_e                mode_q;

    logic                 line_s;
    logic                 fell;
    logic [CNT_W-1:0]     half_m1;
    logic                 period_end;
    logic                 done;
    logic [CHAR_BITS-1:0] full;
    rx_result_t           res;

    rx_result_t           hold_q;
    logic                 valid_q;
    logic                 unread_q;
    logic                 ovr_q;

    assign line_s     = sync_q[1];
    assign fell       = sync_q[2] & ~sync_q[1];
    assign half_m1    = (bit_cycles >> 1) - 1'b1;
    assign period_end = (cnt_q == bit_cycles - 1'b1);
    assign done       = (st_q == RX_BITS) && period_end && (idx_q == IDX_W'(CHAR_BITS - 1));
    assign full       = {line_s, sh_q[CHAR_BITS-1:1]};
    assign res        = dec_char(full, mode_q);

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[1:0], line_i};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= RX_IDLE;
            cnt_q  <= '0;
            idx_q  <= '0;
            sh_q   <= '0;
            mode_q <= CONV_DIRECT;
        end else begin
            unique case (st_q)
                RX_IDLE: begin
                    if (fell) begin
                        st_q   <= RX_START;
                        cnt_q  <= '0;
                        mode_q <= mode_i;
                    end
                end
                RX_START: begin
                    if (cnt_q == half_m1) begin
                        cnt_q <= '0;
                        idx_q <= '0;
                        st_q  <= line_s ? RX_IDLE : RX_BITS;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                RX_BITS: begin
                    if (period_end) begin
                        cnt_q <= '0;
                        sh_q  <= full;
                        if (idx_q == IDX_W'(CHAR_BITS - 1)) st_q <= RX_IDLE;
                        else                                idx_q <= idx_q + 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: st_q <= RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q   <= '0;
            valid_q  <= 1'b0;
            unread_q <= 1'b0;
            ovr_q    <= 1'b0;
        end else begin
            valid_q <= done;
            if (done) begin
                hold_q   <= res;
                unread_q <= 1'b1;
                ovr_q    <= unread_q & ~read_i;
            end else if (read_i) begin
                unread_q <= 1'b0;
                ovr_q    <= 1'b0;
            end
        end
    end

    assign data_o    = hold_q.data;
    assign perr_o    = hold_q.perr;
    assign valid_o   = valid_q;
    assign overrun_o = ovr_q;

    p_valid_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        valid_q |=> !valid_q);

    p_overrun_set_r10: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> (ovr_q == ($past(unread_q) && !$past(read_i))));

    p_read_clears_r10: assert property (@(posedge clk) disable iff (rst)
        (read_i && !done) |=> !ovr_q);

    p_start_confirmed_r12: assert property (@(posedge clk) disable iff (rst)
        (st_q == RX_BITS && $past(st_q) == RX_START) |-> !$past(line_s));

    p_mode_held_r11: assert property (@(posedge clk) disable iff (rst)
        (st_q != RX_IDLE && $past(st_q) != RX_IDLE) |-> $stable(mode_q));

endmodule

// File: rtl/sc_codec.sv
module sc_codec
    import sc_codec_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              conv_inverse,
    input  logic [CNT_W-1:0]  bit_cycles,
    input  logic              tx_start,
    input  logic [7:0]        tx_data,
    output logic              tx_busy,
    output logic              line_out,
    input  logic              line_in,
    input  logic              rx_read,
    output logic [7:0]        rx_data,
    output logic              rx_parity_err,
    output logic              rx_valid,
    output logic              rx_overrun
);
    conv_e mode;
    assign mode = conv_e'(conv_inverse);

    sc_tx #(.CNT_W(CNT_W)) u_tx (
        .clk        (clk),
        .rst        (rst),
        .mode_i     (mode),
        .bit_cycles (bit_cycles),
        .start_i    (tx_start),
        .data_i     (tx_data),
        .busy_o     (tx_busy),
        .line_o     (line_out)
    );

    sc_rx #(.CNT_W(CNT_W)) u_rx (
        .clk        (clk),
        .rst        (rst),
        .mode_i     (mode),
        .bit_cycles (bit_cycles),
        .line_i     (line_in),
        .read_i     (rx_read),
        .data_o     (rx_data),
        .perr_o     (rx_parity_err),
        .valid_o    (rx_valid),
        .overrun_o  (rx_overrun)
    );

    p_idle_high_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_busy) |-> line_out);

endmodule

// File: tb/tb_sc_codec.sv
module tb_sc_codec;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        conv_inverse = 1'b0;
    logic [15:0] bit_cycles = 16'd8;
    logic        tx_start = 1'b0;
    logic [7:0]  tx_data = 8'h00;
    logic        tx_busy, line_out, line_in;
    logic        rx_read = 1'b0;
    logic [7:0]  rx_data;
    logic        rx_parity_err, rx_valid, rx_overrun;
    logic        loop = 1'b0;
    logic        tb_line = 1'b1;

    int checks = 0;
    int errors = 0;
    int cap_n = 0;
    logic [7:0] cap_d;
    logic       cap_e, cap_o;
    bit         finished = 0;

    always #4 clk = ~clk;

    assign line_in = loop ? line_out : tb_line;

    sc_codec #(.CNT_W(16)) dut (
        .clk(clk), .rst(rst), .conv_inverse(conv_inverse), .bit_cycles(bit_cycles),
        .tx_start(tx_start), .tx_data(tx_data), .tx_busy(tx_busy), .line_out(line_out),
        .line_in(line_in), .rx_read(rx_read), .rx_data(rx_data),
        .rx_parity_err(rx_parity_err), .rx_valid(rx_valid), .rx_overrun(rx_overrun)
    );

    always @(negedge clk) begin
        if (rx_valid) begin
            cap_n = cap_n + 1;
            cap_d = rx_data;
            cap_e = rx_parity_err;
            cap_o = rx_overrun;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Line bits in send order; [8] is parity.
    function automatic logic [8:0] m_frame(input logic [7:0] d, input logic inv);
        logic [8:0] f;
        int ones = 0;
        for (int k = 0; k < 8; k++) begin
            f[k] = inv ? ~d[7-k] : d[k];
            if (f[k]) ones++;
        end
        f[8] = inv ? ((ones % 2) == 0) : ((ones % 2) == 1);
        return f;
    endfunction

    task automatic read_pulse();
        @(negedge clk); rx_read = 1'b1;
        @(negedge clk); rx_read = 1'b0;
    endtask

    // Transmit with loopback into the receiver. Flips the mode after one
    // period (R11) and strobes again while busy (R5).
    task automatic send_tx(input logic [7:0] d, input logic inv, input int p);
        logic [11:0] got, exp;
        int busy_bad = 0;
        int n0 = cap_n;
        loop = 1'b1;
        bit_cycles = 16'(p);
        exp = {2'b11, m_frame(d, inv), 1'b0};
        @(negedge clk); tx_data = d; conv_inverse = inv; tx_start = 1'b1;
        for (int c = 0; c < 12 * p; c++) begin
            @(negedge clk);
            if (c == 0) tx_start = 1'b0;
            if (c == p) begin conv_inverse = ~inv; tx_data = ~d; end
            if (c == 3 * p) tx_start = 1'b1;
            if (c == 3 * p + 1) tx_start = 1'b0;
            if (c % p == p / 2) got[c / p] = line_out;
            if (!tx_busy) busy_bad++;
        end
        check(got == exp, inv ? "R3 (R5 R11) tx frame inverse" : "R2 (R5 R11) tx frame direct", got, exp);
        check(busy_bad == 0, "R4 busy held for whole frame", busy_bad, 0);
        @(negedge clk);
        check(tx_busy == 1'b0 && line_out == 1'b1, "R4 busy falls after 12 periods, R1 idle high",
              {tx_busy, line_out}, 2'b01);
        check(cap_n == n0 + 1, "R9 one valid per loopback char", cap_n - n0, 1);
        check(cap_d == d && cap_e == 1'b0, inv ? "R7 loopback inverse byte" : "R6 loopback direct byte",
              {cap_e, cap_d}, {1'b0, d});
        conv_inverse = inv;
        read_pulse();
    endtask

    // Bench-driven receive; flip_par corrupts parity.
    task automatic send_rx(input logic [7:0] d, input logic inv, input int p, input bit flip_par,
                           input bit do_read);
        logic [11:0] fr;
        int n0 = cap_n;
        loop = 1'b0;
        bit_cycles = 16'(p);
        fr = {2'b11, m_frame(d, inv) ^ {flip_par, 8'h00}, 1'b0};
        @(negedge clk); conv_inverse = inv;
        for (int b = 0; b < 12; b++) begin
            tb_line = fr[b];
            if (b == 2) conv_inverse = ~inv;
            repeat (p) @(negedge clk);
        end
        tb_line = 1'b1;
        conv_inverse = inv;
        check(cap_n == n0 + 1, "R9 one valid per received char", cap_n - n0, 1);
        check(cap_d == d, inv ? "R7 rx inverse byte (R11)" : "R6 rx direct byte (R11)", cap_d, d);
        check(cap_e == flip_par, "R8 parity error flag", cap_e, flip_par);
        if (do_read) read_pulse();
    endtask

    initial begin
        #(8 * 190000);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int n0;
        void'($urandom(32'hC0DE));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check({line_out, tx_busy, rx_valid, rx_overrun} == 4'b1000, "R1 reset state",
              {line_out, tx_busy, rx_valid, rx_overrun}, 4'b1000);

        // directed transmit corners
        send_tx(8'hA5, 1'b0, 8);
        send_tx(8'hA5, 1'b1, 8);
        send_tx(8'h00, 1'b0, 6);
        send_tx(8'h00, 1'b1, 6);
        send_tx(8'hFF, 1'b1, 9);
        send_tx(8'h01, 1'b0, 7);

        // directed receive corners, including bad parity in each mode
        send_rx(8'h3B, 1'b0, 8, 1'b0, 1'b1);
        send_rx(8'h3B, 1'b1, 8, 1'b0, 1'b1);
        send_rx(8'h80, 1'b0, 10, 1'b1, 1'b1);
        send_rx(8'h80, 1'b1, 10, 1'b1, 1'b1);

        // false start: glitch far shorter than half a period
        bit_cycles = 16'd16;
        n0 = cap_n;
        @(negedge clk); tb_line = 1'b0;
        repeat (2) @(negedge clk); tb_line = 1'b1;
        repeat (16 * 13) @(negedge clk);
        check(cap_n == n0, "R12 glitch rejected", cap_n - n0, 0);
        send_rx(8'h5A, 1'b0, 16, 1'b0, 1'b1);

        // overrun
        send_rx(8'h11, 1'b0, 8, 1'b0, 1'b0);
        check(cap_o == 1'b0, "R10 no overrun after read byte", cap_o, 0);
        send_rx(8'h22, 1'b1, 8, 1'b0, 1'b0);
        check(cap_o == 1'b1, "R10 overrun on unread byte", cap_o, 1);
        check(rx_data == 8'h22, "R9 held byte overwritten", rx_data, 8'h22);
        read_pulse();
        @(negedge clk);
        check(rx_overrun == 1'b0, "R10 read clears overrun", rx_overrun, 0);

        // constrained random mix
        for (int it = 0; it < 40; it++) begin
            logic [7:0] d = 8'($urandom);
            logic inv = 1'($urandom);
            int p = 6 + int'($urandom % 15);
            if (it % 2 == 0) send_tx(d, inv, p);
            else             send_rx(d, inv, p, 1'($urandom % 3 == 0), 1'b1);
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule